// File: doc/BRIEF.md
# Bridging-Fault Test Sweep Sequencer

This block drives a small testable exclusive-OR sum-of-products network through a complete bridging-fault campaign. It applies a fixed table of `N_DATA+5` test vectors, one per clock, to the network's `N_DATA+4` primary lines. It samples the three network outputs (the function output and the two auxiliary AND and OR outputs) in every applying cycle, and packs each output's bit stream into a signature. The network and the vector table sit outside the block. The table arrives as one flat input bus, and the network answers combinationally in the same cycle.

A run starts with a fault-free pass that captures the golden signature triple. After that, every unordered pair of primary lines is bridged twice: once as a wired-OR and once as a wired-AND. The triple from each faulted pass goes into an on-chip table and is compared with the golden triple. A closing pass compares every table entry with every other entry. When the run finishes, the block raises `done` and holds three counts: the faults recorded, the faults that cannot be told apart from a fault-free network, and the faults whose triple also occurs for some other fault.

The interface is plain control and status. There is no streaming data and no back-pressure: `start` is a level sampled on the clock, and the network must answer within the cycle in which `net_apply` is high.

Top module: `bft_seq`

## Requirements
- R1: Table entry k occupies `vec_table[k*L +: L]` with L = N_DATA+4. Bit 0..3 of an entry are control lines 1..4, and bit 4+m is data line m+1. Bit p of `net_in` drives line p. While `net_apply` is high, the block applies the entries in order 0..N_DATA+4, one per cycle. While `net_apply` is low, `net_in` is all zero.
- R2: The first pass of every run applies the table without a fault. Each output's signature is N_DATA+5 bits wide, and the bit sampled with vector 0 is the most significant bit.
- R3: After the fault-free pass, one pass runs for each fault. Line pairs (i,j) with i<j are taken in lexicographic order, and each pair runs twice, the wired-OR variant first and then the wired-AND variant. That gives 2·C(L,2) faulted passes.
- R4: In a faulted pass, both bridged lines carry the OR (variant 1st) or the AND (variant 2nd) of their two table values. Every other line carries its table value, so at most two lines differ from the entry.
- R5: `cnt_unid` counts the faults whose three signatures all equal the fault-free ones.
- R6: `cnt_ind` counts the faults whose signature triple equals that of at least one other fault.
- R7: At the end of the run, `done` is high and `cnt_total` equals 2·C(L,2). `done` and all counts hold while `start` stays low.
- R8: A `start` that is high while a run is in progress (not idle, not done) has no effect on the vector sequence or on the results.
- R9: A `start` sampled while idle or done launches a new run. On that edge the block clears all counts, and `done` is low in the next cycle.
- R10: A synchronous active-high `rst` makes `done` and `net_apply` low, `net_in` zero and all counts zero, and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run when idle or done |
| vec_table | input | (N_DATA+5)*(N_DATA+4) | Flattened test-vector table |
| net_in | output | N_DATA+4 | Primary lines driven into the network |
| net_apply | output | 1 | High while `net_in` carries a vector being sampled |
| net_f | input | 1 | Network function output |
| net_o1 | input | 1 | Network auxiliary AND output |
| net_o2 | input | 1 | Network auxiliary OR output |
| done | output | 1 | Run finished, counts valid |
| cnt_total | output | clog2(2·C(L,2)+1) | Faults recorded |
| cnt_unid | output | clog2(2·C(L,2)+1) | Unidentifiable faults |
| cnt_ind | output | clog2(2·C(L,2)+1) | Indistinguishable faults |

## Verification
Two controls can meet on one edge. A launch request can arrive while the block is applying vectors, and a launch request can arrive in the same cycle as held results. The bench holds `start` high for many cycles across the fault-free pass and into the first faulted passes. It then judges the cycle-by-cycle line sequence against its own pair order and the final counts against arithmetic over its own network model; a restart would show up as a repeated fault-free pass. It also launches a run directly from the done state. There it expects `done` to drop and all counts to read zero at the next sample, and it expects the following sweep to produce fresh totals for a different vector table.

// File: rtl/bft_pkg.sv
package bft_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RUN,
    SQ_POST,
    SQ_CMP,
    SQ_DONE
  } seq_state_t;

  function automatic int pair_count(input int lines);
    return (lines * (lines - 1)) / 2;
  endfunction

endpackage

// File: rtl/bft_inject.sv
module bft_inject #(
  parameter int L  = 7,
  parameter int LW = 3
) (
  input  logic [L-1:0]  vec,
  input  logic          fault_en,
  input  logic [LW-1:0] sel_a,
  input  logic [LW-1:0] sel_b,
  input  logic          use_and,
  output logic [L-1:0]  lines
);

  logic bit_a, bit_b, joined;

  always_comb begin
    bit_a  = vec[sel_a];
    bit_b  = vec[sel_b];
    joined = use_and ? (bit_a & bit_b) : (bit_a | bit_b);
  end

  for (genvar p = 0; p < L; p++) begin : g_line
    logic hit;
    assign hit      = fault_en && ((sel_a == LW'(p)) || (sel_b == LW'(p)));
    assign lines[p] = hit ? joined : vec[p];
  end

endmodule

// File: rtl/bft_sigreg.sv
module bft_sigreg #(
  parameter int V = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic [2:0]     din,
  output logic [3*V-1:0] sig
);

  for (genvar g = 0; g < 3; g++) begin : g_out
    logic [V-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst)           sr <= '0;
      else if (shift_en) sr <= {sr[V-2:0], din[g]};
    end
    assign sig[g*V +: V] = sr;
  end

endmodule

// File: rtl/bft_sigtab.sv
module bft_sigtab #(
  parameter int NF = 42,
  parameter int SW = 24,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [FW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic [FW-1:0] raddr_a,
  input  logic [FW-1:0] raddr_b,
  output logic [SW-1:0] rdata_a,
  output logic [SW-1:0] rdata_b
);

  logic [SW-1:0] mem [NF];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/bft_seq.sv
module bft_seq
  import bft_pkg::*;
#(
  parameter int N_DATA = 3
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         start,
  input  logic [(N_DATA+5)*(N_DATA+4)-1:0]             vec_table,
  output logic [N_DATA+3:0]                            net_in,
  output logic                                         net_apply,
  input  logic                                         net_f,
  input  logic                                         net_o1,
  input  logic                                         net_o2,
  output logic                                         done,
  output logic [$clog2((N_DATA+4)*(N_DATA+3)+1)-1:0]   cnt_total,
  output logic [$clog2((N_DATA+4)*(N_DATA+3)+1)-1:0]   cnt_unid,
  output logic [$clog2((N_DATA+4)*(N_DATA+3)+1)-1:0]   cnt_ind
);

  localparam int L  = N_DATA + 4;
  localparam int V  = N_DATA + 5;
  localparam int NF = 2 * pair_count(L);
  localparam int SW = 3 * V;
  localparam int FW = $clog2(NF);
  localparam int CW = $clog2(NF + 1);
  localparam int LW = $clog2(L);
  localparam int VW = $clog2(V);

  seq_state_t    state;
  logic [VW-1:0] k;
  logic          golden_pass;
  logic [LW-1:0] sel_a, sel_b;
  logic          use_and;
  logic [FW-1:0] fidx;
  logic [SW-1:0] golden_sig;
  logic [FW-1:0] cmp_a, cmp_b;
  logic          hit;

  logic [L-1:0]  cur_vec;
  logic [L-1:0]  faulted;
  logic [SW-1:0] sig_now;
  logic [SW-1:0] rd_a, rd_b;
  logic          tab_we;
  logic          match;
  logic          last_fault;

  always_comb cur_vec = vec_table[int'(k) * L +: L];

  bft_inject #(.L(L), .LW(LW)) u_inject (
    .vec      (cur_vec),
    .fault_en (!golden_pass),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .use_and  (use_and),
    .lines    (faulted)
  );

  assign net_apply = (state == SQ_RUN);
  assign net_in    = net_apply ? faulted : '0;
  assign done      = (state == SQ_DONE);

  bft_sigreg #(.V(V)) u_sig (
    .clk      (clk),
    .rst      (rst),
    .shift_en (net_apply),
    .din      ({net_f, net_o1, net_o2}),
    .sig      (sig_now)
  );

  assign tab_we = (state == SQ_POST) && !golden_pass;

  bft_sigtab #(.NF(NF), .SW(SW), .FW(FW)) u_tab (
    .clk     (clk),
    .we      (tab_we),
    .waddr   (fidx),
    .wdata   (sig_now),
    .raddr_a (cmp_a),
    .raddr_b (cmp_b),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  assign match      = (cmp_a != cmp_b) && (rd_a == rd_b);
  assign last_fault = use_and && (sel_a == LW'(L - 2)) && (sel_b == LW'(L - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      k           <= '0;
      golden_pass <= 1'b1;
      sel_a       <= '0;
      sel_b       <= LW'(1);
      use_and     <= 1'b0;
      fidx        <= '0;
      golden_sig  <= '0;
      cmp_a       <= '0;
      cmp_b       <= '0;
      hit         <= 1'b0;
      cnt_total   <= '0;
      cnt_unid    <= '0;
      cnt_ind     <= '0;
    end else begin
      unique case (state)
        SQ_IDLE, SQ_DONE: begin
          if (start) begin
            state       <= SQ_RUN;
            k           <= '0;
            golden_pass <= 1'b1;
            sel_a       <= '0;
            sel_b       <= LW'(1);
            use_and     <= 1'b0;
            fidx        <= '0;
            cnt_total   <= '0;
            cnt_unid    <= '0;
            cnt_ind     <= '0;
          end
        end
        SQ_RUN: begin
          if (k == VW'(V - 1)) begin
            k     <= '0;
            state <= SQ_POST;
          end else begin
            k <= k + VW'(1);
          end
        end
        SQ_POST: begin
          if (golden_pass) begin
            golden_sig  <= sig_now;
            golden_pass <= 1'b0;
            state       <= SQ_RUN;
          end else begin
            cnt_total <= cnt_total + CW'(1);
            if (sig_now == golden_sig) cnt_unid <= cnt_unid + CW'(1);
            fidx <= fidx + FW'(1);
            if (last_fault) begin
              state <= SQ_CMP;
              cmp_a <= '0;
              cmp_b <= '0;
              hit   <= 1'b0;
            end else begin
              state <= SQ_RUN;
              if (!use_and) begin
                use_and <= 1'b1;
              end else begin
                use_and <= 1'b0;
                if (sel_b == LW'(L - 1)) begin
                  sel_a <= sel_a + LW'(1);
                  sel_b <= sel_a + LW'(2);
                end else begin
                  sel_b <= sel_b + LW'(1);
                end
              end
            end
          end
        end
        SQ_CMP: begin
          if (cmp_b == FW'(NF - 1)) begin
            if (hit || match) cnt_ind <= cnt_ind + CW'(1);
            hit   <= 1'b0;
            cmp_b <= '0;
            if (cmp_a == FW'(NF - 1)) state <= SQ_DONE;
            else                      cmp_a <= cmp_a + FW'(1);
          end else begin
            cmp_b <= cmp_b + FW'(1);
            hit   <= hit | match;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bft_seq_chk.sv
module bft_seq_chk #(
  parameter int L  = 7,
  parameter int NF = 42,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          net_apply,
  input logic [L-1:0]  net_in,
  input logic [L-1:0]  cur_vec,
  input logic [CW-1:0] cnt_total,
  input logic [CW-1:0] cnt_unid,
  input logic [CW-1:0] cnt_ind
);

  p_quiet_lines_r1: assert property (@(posedge clk) disable iff (rst)
    !net_apply |-> net_in == '0);

  p_fault_local_r4: assert property (@(posedge clk) disable iff (rst)
    net_apply |-> $countones(net_in ^ cur_vec) <= 2);

  p_unid_bound_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> cnt_unid <= cnt_total);

  p_ind_bound_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> cnt_ind <= cnt_total);

  p_done_total_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> cnt_total == CW'(NF));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(cnt_unid) && $stable(cnt_ind)));

  p_relaunch_r9: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (!done && cnt_total == '0 && cnt_unid == '0 && cnt_ind == '0));

endmodule

bind bft_seq bft_seq_chk #(.L(L), .NF(NF), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .done      (done),
  .net_apply (net_apply),
  .net_in    (net_in),
  .cur_vec   (cur_vec),
  .cnt_total (cnt_total),
  .cnt_unid  (cnt_unid),
  .cnt_ind   (cnt_ind)
);

// File: tb/tb_bft_seq.sv
`timescale 1ns/1ps
module tb_bft_seq;

  localparam int N  = 3;
  localparam int L  = N + 4;
  localparam int V  = N + 5;
  localparam int NF = L * (L - 1);
  localparam int SW = 3 * V;
  localparam int CW = $clog2(NF + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [V*L-1:0] tbl = '0;
  logic [L-1:0]   net_in;
  logic           net_apply, net_f, net_o1, net_o2, done;
  logic [CW-1:0]  c_tot, c_unid, c_ind;

  int checks = 0;
  int errors = 0;
  int mon_pass, mon_k;
  int ea [NF];
  int eb [NF];
  int ew [NF];
  int exp_unid, exp_ind;

  always #10 clk = ~clk;

  function automatic logic [2:0] net_eval(input logic [L-1:0] ln);
    logic c1, c2, c3, c4, x1, x2, x3, f;
    {x3, x2, x1, c4, c3, c2, c1} = ln;
    f = (x1 & c1) ^ (x2 & x3 & c2) ^ ((x1 ^ c3) & x2 & x3 & c4);
    return {f, &ln, |ln};
  endfunction

  assign {net_f, net_o1, net_o2} = net_eval(net_in);

  bft_seq #(.N_DATA(N)) dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .vec_table (tbl),
    .net_in    (net_in),
    .net_apply (net_apply),
    .net_f     (net_f),
    .net_o1    (net_o1),
    .net_o2    (net_o2),
    .done      (done),
    .cnt_total (c_tot),
    .cnt_unid  (c_unid),
    .cnt_ind   (c_ind)
  );

  function automatic logic [L-1:0] bridge(input logic [L-1:0] v, input int a, input int b, input int w);
    logic [L-1:0] r;
    logic j;
    r = v;
    if (a >= 0) begin
      j = (w != 0) ? (v[a] & v[b]) : (v[a] | v[b]);
      r[a] = j;
      r[b] = j;
    end
    return r;
  endfunction

  function automatic logic [SW-1:0] sig_of(input int a, input int b, input int w);
    logic [SW-1:0] s;
    logic [2:0] t;
    s = '0;
    for (int kk = 0; kk < V; kk++) begin
      t = net_eval(bridge(tbl[kk*L +: L], a, b, w));
      s[3*V-1-kk] = t[2];
      s[2*V-1-kk] = t[1];
      s[V-1-kk]   = t[0];
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compute_expected();
    logic [SW-1:0] gold;
    logic [SW-1:0] sg [NF];
    bit h;
    gold = sig_of(-1, 0, 0);
    exp_unid = 0;
    exp_ind  = 0;
    for (int f = 0; f < NF; f++) begin
      sg[f] = sig_of(ea[f], eb[f], ew[f]);
      if (sg[f] == gold) exp_unid++;
    end
    for (int a = 0; a < NF; a++) begin
      h = 0;
      for (int b = 0; b < NF; b++)
        if (a != b && sg[a] == sg[b]) h = 1;
      if (h) exp_ind++;
    end
  endtask

  // One negedge sample; the line sequence is judged against R1/R2/R3/R4
  task automatic step();
    logic [L-1:0] e;
    @(negedge clk);
    if (net_apply) begin
      if (mon_pass == 0) begin
        e = tbl[mon_k*L +: L];
        chk(net_in == e, "R2 fault-free vector", int'(net_in), int'(e));
      end else if (mon_pass <= NF) begin
        e = bridge(tbl[mon_k*L +: L], ea[mon_pass-1], eb[mon_pass-1], ew[mon_pass-1]);
        chk(net_in == e, "R3/R4 faulted vector", int'(net_in), int'(e));
      end else begin
        chk(0, "R3 extra pass", mon_pass, NF);
      end
      mon_k++;
      if (mon_k == V) begin
        mon_k = 0;
        mon_pass++;
      end
    end else begin
      if (net_in != '0) chk(0, "R1 lines idle", int'(net_in), 0);
    end
  endtask

  task automatic run_case(input string name, input int hold);
    int n;
    compute_expected();
    mon_pass = 0;
    mon_k    = 0;
    start    = 1'b1;
    step();
    chk(!done, "R9 done drops", int'(done), 0);
    chk(c_tot == 0 && c_unid == 0 && c_ind == 0, "R9 counts cleared",
        int'(c_tot) + int'(c_unid) + int'(c_ind), 0);
    for (int h = 1; h < hold; h++) step();
    start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      step();
      n++;
    end
    chk(done, "R7 watchdog", n, 20000);
    $display("case %s: total=%0d unid=%0d ind=%0d", name, c_tot, c_unid, c_ind);
    chk(mon_pass == NF + 1, "R3 pass count", mon_pass, NF + 1);
    chk(int'(c_tot) == NF, "R7 total", int'(c_tot), NF);
    chk(int'(c_unid) == exp_unid, "R5 unidentifiable", int'(c_unid), exp_unid);
    chk(int'(c_ind) == exp_ind, "R6 indistinguishable", int'(c_ind), exp_ind);
    if (hold > 1) chk(int'(c_unid) == exp_unid && mon_pass == NF + 1,
                      "R8 busy start ignored", mon_pass, NF + 1);
    repeat (4) step();
    chk(done && int'(c_unid) == exp_unid && int'(c_ind) == exp_ind, "R7 hold",
        int'(c_unid), exp_unid);
  endtask

  initial begin
    int f;
    logic [31:0] lcg;
    f = 0;
    for (int i = 0; i < L; i++)
      for (int j = i + 1; j < L; j++)
        for (int w = 0; w < 2; w++) begin
          ea[f] = i; eb[f] = j; ew[f] = w;
          f++;
        end

    repeat (3) @(negedge clk);
    chk(!done && !net_apply && net_in == '0, "R10 reset outputs", int'(net_in), 0);
    chk(c_tot == 0 && c_unid == 0 && c_ind == 0, "R10 reset counts",
        int'(c_tot) + int'(c_unid) + int'(c_ind), 0);
    rst = 1'b0;
    mon_pass = 0;
    mon_k    = 0;
    repeat (3) step();
    chk(!done && !net_apply, "R9 idle without start", int'(net_apply), 0);

    // walking-zero table plus an all-zero last vector
    for (int kk = 0; kk < V; kk++)
      tbl[kk*L +: L] = (kk < L) ? ~(L'(1) << kk) : '0;
    run_case("walking", 1);

    // all-zero table, launched straight from done
    tbl = '0;
    run_case("zeros", 1);

    // pseudo-random table, start held high into the faulted passes
    lcg = 32'h1234_5678;
    for (int kk = 0; kk < V; kk++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      tbl[kk*L +: L] = lcg[22:16];
    end
    run_case("random", 3 * V + 5);

    rst = 1'b1;
    step();
    chk(!done && c_tot == 0 && c_unid == 0 && c_ind == 0, "R10 reset after run",
        int'(c_tot), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule